// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This controller brings a bank of supply regulators up in an orderly way once power arrives. It first waits a fixed initialisation period. It then captures the configuration strap pins in one sampling step. After that it turns the regulators on one at a time, each in its own fixed-length time slot, so that inrush current stays bounded. Every regulator that is switched on runs in forced-PWM mode for a fixed settling window. After the window it follows the mode bit that software has programmed for it.

All time is counted in pulses of a one-per-millisecond tick input. The initialisation period, slot length and PWM window are parameters in ticks, and so is the slot order. A slot whose regulator is disabled by the latched straps is skipped, but it still takes its full length, so the timing of later slots does not move. A power-cut pulse sends the controller back to the start with every enable cleared.

The block has no streaming data path. Every pin is a plain level or a single-cycle pulse with no handshake, so back-pressure never applies.

Top module: `pwrup_seq`

## Requirements
- R1: After reset, or after a power-cut, no regulator enable is asserted until INIT_TICKS (default 8) ms_tick pulses have been counted.
- R2: Slot k enables the regulator named by entry k of SLOT_ORDER, and each slot lasts SLOT_TICKS (default 2) ticks. The default order is reg1, reg0, reg2, reg3, reg5, reg4. At most one enable goes from 0 to 1 in any cycle, and an enable never clears except on reset or power-cut.
- R3: Each discharge output dis_en[i] is high exactly when reg_en[i] is low.
- R4: uv_mask is high from reset until the sequence finishes, and uv_out = uv_in AND NOT uv_mask. Once done, or once a configuration error has stopped the sequence, the mask is low.
- R5: mode_sel[i] is 0 (forced PWM) from the moment reg_en[i] rises until PWM_TICKS (default 3) ticks have passed after it. From then on it equals sw_mode[i].
- R6: strap[4:0] is sampled once, at the end of initialisation. Later changes to the pins have no effect. pass_sel outputs the latched strap[4] (1 = internal PMOS, 0 = external PNP) and reads 0 before the latch.
- R7: A pcut pulse clears every enable, done and cfg_err in the next cycle. When pcut is released, the whole sequence starts over.
- R8: A latched strap[3:0] value of 0 to 4 is reserved. It sets cfg_err, stops the sequence before any slot, leaves all enables low and releases uv_mask.
- R9: The boost regulator (reg5) is never enabled. Its slot still takes SLOT_TICKS, so every later slot keeps its timing.
- R10: The auxiliary regulator (reg4) is enabled in its slot only when latched strap[0] is 1. Otherwise its slot is skipped.
- R11: done rises once the last slot has ended and every enabled regulator's PWM window has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pcut | input | 1 | Power-cut restart, synchronous, active high |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| strap | input | 5 | Configuration strap pins |
| uv_in | input | 1 | Raw undervoltage flag of the main supply |
| sw_mode | input | N_REG | Software-selected mode bit for each regulator |
| reg_en | output | N_REG | Regulator enables |
| dis_en | output | N_REG | Weak pull-down discharge enables |
| mode_sel | output | N_REG | Mode select for each regulator (0 = forced PWM) |
| uv_mask | output | 1 | Undervoltage mask, high while sequencing |
| uv_out | output | 1 | Undervoltage flag after the mask |
| pass_sel | output | 1 | Latched pass-device select (strap[4]) |
| cfg_err | output | 1 | Reserved strap code was latched |
| done | output | 1 | Sequence finished |

## Verification
The bench checks the enable mask at the tick where each slot opens. A design with an off-by-one initialisation or slot count would show an enable one tick early or late. It runs one strap code that turns the auxiliary regulator on and one that turns it off. Both runs check that the boost slot keeps its length, since a design that collapsed skipped slots would enable later regulators early. A reserved code must leave every enable low. A strap change after the latch and a power-cut in the middle of the sequence must neither change pass_sel nor leave an enable behind. The bench also checks the PWM-to-software handover at the exact tick and the masking of undervoltage.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [2:0] {
    S_INIT, S_LATCH, S_DECIDE, S_SLOT, S_TAIL, S_DONE, S_ERR
  } seq_state_t;

  function automatic logic code_reserved(input logic [3:0] code, input int unsigned res_max);
    return 32'(code) <= res_max;
  endfunction
endpackage

// File: rtl/pwrup_strap_latch.sv
module pwrup_strap_latch #(
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned RES_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcut,
  input  logic              capture,
  input  logic [CODE_W:0]   strap,
  output logic              pass_sel,
  output logic              reserved,
  output logic              aux_allow
);
  logic [CODE_W-1:0] code_q;
  logic              pass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      pass_q <= 1'b0;
    end else if (pcut) begin
      code_q <= '0;
      pass_q <= 1'b0;
    end else if (capture) begin
      code_q <= strap[CODE_W-1:0];
      pass_q <= strap[CODE_W];
    end
  end

  assign pass_sel  = pass_q;
  assign reserved  = pwrup_pkg::code_reserved(code_q[3:0], RES_MAX);
  assign aux_allow = code_q[0];

  // R6: the latched straps move only on a capture or a power-cut
  a_r6_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !pcut) |=> ($stable(code_q) && $stable(pass_q)));
endmodule

// File: rtl/pwrup_pwm_window.sv
module pwrup_pwm_window #(
  parameter int unsigned PWM_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pcut,
  input  logic ms_tick,
  input  logic en,
  input  logic sw_mode,
  output logic mode_o,
  output logic settled
);
  localparam int unsigned CW = $clog2(PWM_TICKS + 1);
  logic [CW-1:0] cnt;
  logic          expired;

  assign expired = (cnt == CW'(PWM_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (pcut || !en)    cnt <= '0;
    else if (ms_tick && !expired) cnt <= cnt + CW'(1);
  end

  assign mode_o  = (en && expired) ? sw_mode : 1'b0;
  assign settled = !en || expired;

  // R5: a freshly enabled regulator always starts inside its PWM window
  a_r5_window_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> !expired);
  // R5: the window counter never runs past its limit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PWM_TICKS));
endmodule

// File: rtl/pwrup_slot_fsm.sv
module pwrup_slot_fsm #(
  parameter int unsigned N_REG      = 6,
  parameter int unsigned N_SLOT     = 6,
  parameter int unsigned IDX_W      = 3,
  parameter logic [N_SLOT-1:0][IDX_W-1:0] SLOT_ORDER = '0,
  parameter int unsigned INIT_TICKS = 8,
  parameter int unsigned SLOT_TICKS = 2,
  parameter int unsigned BOOST_IDX  = 5,
  parameter int unsigned AUX_IDX    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pcut,
  input  logic             ms_tick,
  input  logic             reserved,
  input  logic             aux_allow,
  input  logic             all_settled,
  output logic             capture,
  output logic [N_REG-1:0] reg_en,
  output logic             uv_mask,
  output logic             cfg_err,
  output logic             done
);
  import pwrup_pkg::*;

  localparam int unsigned CNT_MAX = (INIT_TICKS > SLOT_TICKS) ? INIT_TICKS : SLOT_TICKS;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam int unsigned SLOT_W  = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [SLOT_W-1:0] idx, nxt_idx;
  logic [IDX_W-1:0] first_reg, nxt_reg;

  function automatic logic allowed(input logic [IDX_W-1:0] r, input logic aux_ok);
    return (32'(r) != BOOST_IDX) && (aux_ok || (32'(r) != AUX_IDX));
  endfunction

  assign nxt_idx   = idx + SLOT_W'(1);
  assign first_reg = SLOT_ORDER[0];
  assign nxt_reg   = SLOT_ORDER[nxt_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_INIT;
      cnt    <= '0;
      idx    <= '0;
      reg_en <= '0;
    end else if (pcut) begin
      state  <= S_INIT;
      cnt    <= '0;
      idx    <= '0;
      reg_en <= '0;
    end else begin
      case (state)
        S_INIT: if (ms_tick) begin
          if (cnt == CNT_W'(INIT_TICKS - 1)) begin
            cnt   <= '0;
            state <= S_LATCH;
          end else cnt <= cnt + CNT_W'(1);
        end
        S_LATCH: state <= S_DECIDE;
        S_DECIDE: begin
          if (reserved) state <= S_ERR;
          else begin
            state <= S_SLOT;
            idx   <= '0;
            if (allowed(first_reg, aux_allow)) reg_en[first_reg] <= 1'b1;
          end
        end
        S_SLOT: if (ms_tick) begin
          if (cnt == CNT_W'(SLOT_TICKS - 1)) begin
            cnt <= '0;
            if (32'(idx) == N_SLOT - 1) state <= S_TAIL;
            else begin
              idx <= nxt_idx;
              if (allowed(nxt_reg, aux_allow)) reg_en[nxt_reg] <= 1'b1;
            end
          end else cnt <= cnt + CNT_W'(1);
        end
        S_TAIL: if (all_settled) state <= S_DONE;
        default: ;
      endcase
    end
  end

  assign capture = (state == S_LATCH);
  assign uv_mask = (state != S_DONE) && (state != S_ERR);
  assign cfg_err = (state == S_ERR);
  assign done    = (state == S_DONE);

  // R1: nothing is enabled before the straps have been taken
  a_r1_quiet_init: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INIT || state == S_LATCH) |-> (reg_en == '0));
  // R2: at most one new enable per cycle
  a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reg_en & ~$past(reg_en)) <= 1);
  // R9: the boost regulator is never switched on
  a_r9_no_boost: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en[BOOST_IDX]);
  // R8: a reserved code leaves every enable low
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ERR) |-> (reg_en == '0));
  // R7: power-cut wipes all enables and restarts
  a_r7_pcut_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pcut |=> (reg_en == '0 && state == S_INIT));
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int unsigned N_REG      = 6,
  parameter int unsigned N_SLOT     = 6,
  parameter int unsigned IDX_W      = (N_REG > 1) ? $clog2(N_REG) : 1,
  parameter logic [N_SLOT-1:0][IDX_W-1:0] SLOT_ORDER =
    {IDX_W'(4), IDX_W'(5), IDX_W'(3), IDX_W'(2), IDX_W'(0), IDX_W'(1)},
  parameter int unsigned INIT_TICKS = 8,
  parameter int unsigned SLOT_TICKS = 2,
  parameter int unsigned PWM_TICKS  = 3,
  parameter int unsigned BOOST_IDX  = 5,
  parameter int unsigned AUX_IDX    = 4,
  parameter int unsigned RES_MAX    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pcut,
  input  logic             ms_tick,
  input  logic [4:0]       strap,
  input  logic             uv_in,
  input  logic [N_REG-1:0] sw_mode,
  output logic [N_REG-1:0] reg_en,
  output logic [N_REG-1:0] dis_en,
  output logic [N_REG-1:0] mode_sel,
  output logic             uv_mask,
  output logic             uv_out,
  output logic             pass_sel,
  output logic             cfg_err,
  output logic             done
);
  logic             capture, reserved, aux_allow, all_settled;
  logic [N_REG-1:0] settled;

  pwrup_strap_latch #(.CODE_W(4), .RES_MAX(RES_MAX)) u_strap (
    .clk(clk), .rst_n(rst_n), .pcut(pcut), .capture(capture), .strap(strap),
    .pass_sel(pass_sel), .reserved(reserved), .aux_allow(aux_allow)
  );

  pwrup_slot_fsm #(
    .N_REG(N_REG), .N_SLOT(N_SLOT), .IDX_W(IDX_W), .SLOT_ORDER(SLOT_ORDER),
    .INIT_TICKS(INIT_TICKS), .SLOT_TICKS(SLOT_TICKS),
    .BOOST_IDX(BOOST_IDX), .AUX_IDX(AUX_IDX)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pcut(pcut), .ms_tick(ms_tick),
    .reserved(reserved), .aux_allow(aux_allow), .all_settled(all_settled),
    .capture(capture), .reg_en(reg_en), .uv_mask(uv_mask),
    .cfg_err(cfg_err), .done(done)
  );

  for (genvar i = 0; i < N_REG; i++) begin : g_win
    pwrup_pwm_window #(.PWM_TICKS(PWM_TICKS)) u_win (
      .clk(clk), .rst_n(rst_n), .pcut(pcut), .ms_tick(ms_tick),
      .en(reg_en[i]), .sw_mode(sw_mode[i]),
      .mode_o(mode_sel[i]), .settled(settled[i])
    );
  end

  assign all_settled = &settled;
  assign dis_en      = ~reg_en;
  assign uv_out      = uv_in & ~uv_mask;

  // R11: done only once every enabled regulator has left its PWM window
  a_r11_done_settled: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> all_settled);
endmodule

// File: tb/tb_pwrup_seq.sv
module tb_pwrup_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pcut = 1'b0;
  logic       ms_tick = 1'b0;
  logic [4:0] strap = '0;
  logic       uv_in = 1'b0;
  logic [5:0] sw_mode = '0;
  logic [5:0] reg_en, dis_en, mode_sel;
  logic       uv_mask, uv_out, pass_sel, cfg_err, done;

  int vectors = 0;
  int errors  = 0;
  int tcount  = 0;
  int divc    = 0;
  bit finished = 0;

  pwrup_seq dut (
    .clk(clk), .rst_n(rst_n), .pcut(pcut), .ms_tick(ms_tick), .strap(strap),
    .uv_in(uv_in), .sw_mode(sw_mode), .reg_en(reg_en), .dis_en(dis_en),
    .mode_sel(mode_sel), .uv_mask(uv_mask), .uv_out(uv_out),
    .pass_sel(pass_sel), .cfg_err(cfg_err), .done(done)
  );

  always #10 clk = ~clk;

  // tick every 5 clocks, changed away from the active edge
  always @(negedge clk) begin
    divc    <= (divc == 4) ? 0 : divc + 1;
    ms_tick <= (divc == 4);
  end

  always @(posedge clk) begin
    if (!rst_n || pcut) tcount <= 0;
    else if (ms_tick)   tcount <= tcount + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // sample three edges after the n-th tick edge, at a falling edge
  task automatic at_tick(input int n);
    while (tcount < n) @(negedge clk);
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    strap = s;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    do_reset(5'b1_0101);
    @(negedge clk);
    chk("R1 reset enables", 32'(reg_en), 0);
    chk("R3 reset discharge", 32'(dis_en), 32'h3f);
    chk("R4 reset mask", 32'(uv_mask), 1);
    chk("R11 reset done", 32'(done), 0);
    chk("R6 pass_sel before latch", 32'(pass_sel), 0);
  endtask

  task automatic t_aux_on;
    sw_mode = 6'h3f;
    uv_in = 1'b1;
    do_reset(5'b1_0101);
    at_tick(7);  chk("R1 no enable at tick 7", 32'(reg_en), 0);
    at_tick(8);  chk("R2 slot0 reg1", 32'(reg_en), 32'h02);
    chk("R6 pass_sel latched", 32'(pass_sel), 1);
    chk("R5 reg1 forced PWM", 32'(mode_sel), 0);
    strap = 5'b0_0011;   // R6: change after latch must be ignored
    at_tick(10); chk("R2 slot1 reg0", 32'(reg_en), 32'h03);
    chk("R5 reg1 still PWM at tick 10", 32'(mode_sel[1]), 0);
    chk("R6 strap change ignored", 32'(pass_sel), 1);
    at_tick(11); chk("R5 reg1 software mode at tick 11", 32'(mode_sel[1]), 1);
    at_tick(12); chk("R2 slot2 reg2", 32'(reg_en), 32'h07);
    chk("R3 discharge complement", 32'(dis_en), 32'h38);
    chk("R4 uv masked while running", 32'(uv_out), 0);
    at_tick(14); chk("R2 slot3 reg3", 32'(reg_en), 32'h0f);
    at_tick(16); chk("R9 boost slot skipped", 32'(reg_en), 32'h0f);
    at_tick(17); chk("R9 boost slot keeps length", 32'(reg_en), 32'h0f);
    at_tick(18); chk("R10 aux enabled on odd code", 32'(reg_en), 32'h1f);
    at_tick(20); chk("R11 not done inside aux window", 32'(done), 0);
    at_tick(21); chk("R11 done after last window", 32'(done), 1);
    chk("R4 uv passes after done", 32'(uv_out), 1);
    chk("R5 all software mode", 32'(mode_sel), 32'h1f);
    chk("R8 no cfg_err", 32'(cfg_err), 0);
    uv_in = 1'b0;
  endtask

  task automatic t_aux_off;
    sw_mode = 6'h00;
    do_reset(5'b0_0110);
    at_tick(8);  chk("R6 pass_sel zero", 32'(pass_sel), 0);
    at_tick(18); chk("R10 aux skipped on even code", 32'(reg_en), 32'h0f);
    chk("R5 sw_mode zero follows", 32'(mode_sel), 0);
    at_tick(19); chk("R11 not done before last slot ends", 32'(done), 0);
    at_tick(20); chk("R11 done when slots end", 32'(done), 1);
  endtask

  task automatic t_reserved;
    uv_in = 1'b1;
    do_reset(5'b1_0011);
    at_tick(8);  chk("R8 cfg_err set", 32'(cfg_err), 1);
    chk("R8 no enables", 32'(reg_en), 0);
    chk("R8 mask released", 32'(uv_mask), 0);
    chk("R8 uv visible", 32'(uv_out), 1);
    at_tick(20); chk("R8 still no enables", 32'(reg_en), 0);
    chk("R8 never done", 32'(done), 0);
    uv_in = 1'b0;
    do_reset(5'b0_0100);
    at_tick(8);  chk("R8 code 4 reserved", 32'(cfg_err), 1);
  endtask

  task automatic t_pcut;
    do_reset(5'b0_1000);
    at_tick(12); chk("R7 before cut", 32'(reg_en), 32'h07);
    pcut = 1'b1;
    @(negedge clk);
    chk("R7 enables cleared", 32'(reg_en), 0);
    chk("R7 discharge all", 32'(dis_en), 32'h3f);
    strap = 5'b1_1001;
    @(negedge clk);
    pcut = 1'b0;
    at_tick(7); chk("R7 R1 no enable in restart init", 32'(reg_en), 0);
    chk("R7 mask back on", 32'(uv_mask), 1);
    at_tick(8); chk("R7 restart slot0", 32'(reg_en), 32'h02);
    chk("R7 straps relatched", 32'(pass_sel), 1);
    at_tick(18); chk("R7 restart aux on new code", 32'(reg_en), 32'h1f);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_aux_on();
    t_aux_off();
    t_reserved();
    t_pcut();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule